// File: doc/BRIEF.md
# Converter Loopback Self-Test Sequencer

This block sequences a loopback self-test of an on-chip data converter pair. When a run is started it steers the DAC input to either the tone synthesizer or a manually loaded register. It steers the ADC input to the DAC output. While the synthesizer feeds the DAC, it enables the synthesizer clock and presents the frequency word to it.

After a programmable settling delay, the block fires single-cycle conversion triggers at the ADC. It waits for each result and writes every returned sample into a capture memory through an address pointer it owns. The run ends once a record whose length is a power of two has been filled. The block then raises a sticky completion flag and hands both selects back to the external-input and register paths. Spectral analysis of the captured record is done elsewhere.

Top module: `adc_bist_seq`

## Requirements
- R1: After reset, every output is low: no trigger, no write, completion flag clear, both selects on their external/register paths, synthesizer clock disabled and frequency word output zero.
- R2: From the cycle after an accepted start until the run ends, `ain_sel_dac_o` is 1. `dac_src_synth_o` and `synth_clk_en_o` equal the mode captured at start (1 = synthesizer, 0 = register). `fcw_o` holds the frequency word captured at start.
- R3: The first conversion trigger appears after `settle_i`+3 rising edges, counting the edge that sampled the start.
- R4: `soc_o` is a single-cycle pulse. A further pulse is issued only after the previous conversion's done has been received and its sample stored, exactly one cycle after that store.
- R5: `adc_done_i` is ignored unless a conversion is outstanding, and a sample is taken only with it.
- R6: The cycle after done is seen, `mem_we_o` pulses for one cycle. `mem_wdata_o` carries the sample returned with done, and `mem_addr_o` carries the pointer. The pointer is 0 for the first store and rises by one per store.
- R7: A run stores exactly 2^k samples, with k = `rec_log2_i` captured at start. A k larger than ADDR_W is treated as ADDR_W.
- R8: `done_o` rises two cycles after the last store and stays high until the edge that accepts the next start, where it clears.
- R9: `start_i` is ignored while a run is in progress.
- R10: Outside a run, both selects, the synthesizer clock enable and `fcw_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (accepted only while idle) |
| synth_mode_i | input | 1 | DAC source for the run: 1 synthesizer, 0 manual register |
| fcw_i | input | FCW_W | Frequency word for the synthesizer |
| rec_log2_i | input | LEN_W | Record length exponent k |
| settle_i | input | SETTLE_W | Settling delay in cycles |
| adc_done_i | input | 1 | ADC conversion complete |
| adc_data_i | input | DATA_W | ADC result, valid with done |
| fcw_o | output | FCW_W | Frequency word to synthesizer |
| synth_clk_en_o | output | 1 | Synthesizer clock enable |
| dac_src_synth_o | output | 1 | DAC source select, 1 = synthesizer |
| ain_sel_dac_o | output | 1 | ADC input select, 1 = DAC loopback |
| soc_o | output | 1 | Start-of-conversion pulse |
| mem_we_o | output | 1 | Capture memory write enable |
| mem_addr_o | output | ADDR_W | Capture memory address |
| mem_wdata_o | output | DATA_W | Capture memory write data |
| done_o | output | 1 | Sticky run-complete flag |

## Verification
The bench goes after the settling count with a zero delay and with longer delays. A timer that is off by one moves the first trigger and shows up against the model on that exact cycle. A done pulse is injected during settling, and one entry has a long ADC latency. A design that accepts stray done would store the wrong word or trigger early. A start is pulsed mid-run; a design that restarted would reset the pointer and break the address sequence. Records of one sample and an oversize exponent exercise the pointer end test, where a wrong compare stops one store early or late.

// File: rtl/adc_bist_pkg.sv
package adc_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SETTLE,
        ST_CONVERT,
        ST_WAIT_DONE,
        ST_STORE,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/bist_settle_timer.sv
module bist_settle_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    input  logic         tick_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R3: a running count never grows without a reload
    assert_settle_monotonic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && tick_i && !expired_o) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/bist_capture_ptr.sv
module bist_capture_ptr #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic [LEN_W-1:0]  len_log2_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              last_o
);

    logic [ADDR_W-1:0] ptr_d, ptr_q;
    logic [ADDR_W-1:0] end_mask;

    // mask of k ones: highest legal address of a 2^k record
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign end_mask[i] = (32'(len_log2_i) > i);
    end

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i)      ptr_d = '0;
        else if (inc_i) ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ptr_q <= '0;
        else         ptr_q <= ptr_d;
    end

    assign ptr_o  = ptr_q;
    assign last_o = (ptr_q == end_mask);

    // R7: pointer never walks past the end of the record
    assert_ptr_in_record_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_i |-> (ptr_q < end_mask));

endmodule

// File: rtl/adc_bist_seq.sv
module adc_bist_seq
    import adc_bist_pkg::*;
#(
    parameter int FCW_W    = 24,
    parameter int DATA_W   = 12,
    parameter int ADDR_W   = 8,
    parameter int SETTLE_W = 16,
    parameter int LEN_W    = $clog2(ADDR_W + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                synth_mode_i,
    input  logic [FCW_W-1:0]    fcw_i,
    input  logic [LEN_W-1:0]    rec_log2_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                adc_done_i,
    input  logic [DATA_W-1:0]   adc_data_i,
    output logic [FCW_W-1:0]    fcw_o,
    output logic                synth_clk_en_o,
    output logic                dac_src_synth_o,
    output logic                ain_sel_dac_o,
    output logic                soc_o,
    output logic                mem_we_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [DATA_W-1:0]   mem_wdata_o,
    output logic                done_o
);

    localparam logic [LEN_W-1:0] MAX_LOG2 = LEN_W'(ADDR_W);

    typedef struct packed {
        seq_state_e          st;
        logic                done;
        logic                mode;
        logic [FCW_W-1:0]    fcw;
        logic [LEN_W-1:0]    lenk;
        logic [SETTLE_W-1:0] settle;
        logic [DATA_W-1:0]   sample;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic tmr_load, tmr_tick, tmr_expired;
    logic ptr_clr, ptr_inc, ptr_last;
    logic [ADDR_W-1:0] ptr;
    logic active;

    bist_settle_timer #(.W(SETTLE_W)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .value_i   (ctl_q.settle),
        .tick_i    (tmr_tick),
        .expired_o (tmr_expired)
    );

    bist_capture_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ptr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (ptr_clr),
        .inc_i      (ptr_inc),
        .len_log2_i (ctl_q.lenk),
        .ptr_o      (ptr),
        .last_o     (ptr_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_tick = 1'b0;
        ptr_clr  = 1'b0;
        ptr_inc  = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st     = ST_SETUP;
                    ctl_d.done   = 1'b0;
                    ctl_d.mode   = synth_mode_i;
                    ctl_d.fcw    = fcw_i;
                    ctl_d.lenk   = (rec_log2_i > MAX_LOG2) ? MAX_LOG2 : rec_log2_i;
                    ctl_d.settle = settle_i;
                    ptr_clr      = 1'b1;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                ctl_d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                tmr_tick = 1'b1;
                if (tmr_expired) ctl_d.st = ST_CONVERT;
            end
            ST_CONVERT: begin
                ctl_d.st = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (adc_done_i) begin
                    ctl_d.sample = adc_data_i;
                    ctl_d.st     = ST_STORE;
                end
            end
            ST_STORE: begin
                if (ptr_last) begin
                    ctl_d.st = ST_FINISH;
                end else begin
                    ptr_inc  = 1'b1;
                    ctl_d.st = ST_CONVERT;
                end
            end
            ST_FINISH: begin
                ctl_d.done = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active          = (ctl_q.st != ST_IDLE);
    assign ain_sel_dac_o   = active;
    assign dac_src_synth_o = active & ctl_q.mode;
    assign synth_clk_en_o  = active & ctl_q.mode;
    assign fcw_o           = active ? ctl_q.fcw : '0;
    assign soc_o           = (ctl_q.st == ST_CONVERT);
    assign mem_we_o        = (ctl_q.st == ST_STORE);
    assign mem_addr_o      = ptr;
    assign mem_wdata_o     = ctl_q.sample;
    assign done_o          = ctl_q.done;

    assert_soc_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soc_o |=> !soc_o);

    assert_soc_on_loopback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soc_o |-> ain_sel_dac_o);

    assert_we_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |=> !mem_we_o);

    assert_idle_paths_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!ain_sel_dac_o && !dac_src_synth_o && !synth_clk_en_o && fcw_o == '0));

    assert_no_write_with_trigger_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(soc_o && mem_we_o));

endmodule

// File: tb/adc_bist_seq_tb_top.sv
module adc_bist_seq_tb_top;

    localparam int FCW_W = 24, DATA_W = 12, ADDR_W = 8, SETTLE_W = 16;
    localparam int LEN_W = $clog2(ADDR_W + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic start = 0, mode = 0, adc_done = 0;
    logic [FCW_W-1:0] fcw = '0;
    logic [LEN_W-1:0] klog = '0;
    logic [SETTLE_W-1:0] settle = '0;
    logic [DATA_W-1:0] adc_data = '0;

    logic [FCW_W-1:0] fcw_o;
    logic clken_o, src_o, ain_o, soc_o, we_o, done_o;
    logic [ADDR_W-1:0] addr_o;
    logic [DATA_W-1:0] wdata_o;

    adc_bist_seq #(.FCW_W(FCW_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETTLE_W(SETTLE_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .synth_mode_i(mode), .fcw_i(fcw),
        .rec_log2_i(klog), .settle_i(settle), .adc_done_i(adc_done), .adc_data_i(adc_data),
        .fcw_o(fcw_o), .synth_clk_en_o(clken_o), .dac_src_synth_o(src_o), .ain_sel_dac_o(ain_o),
        .soc_o(soc_o), .mem_we_o(we_o), .mem_addr_o(addr_o), .mem_wdata_o(wdata_o), .done_o(done_o));

    int nchk = 0, nfail = 0, cyc = 0;

    task automatic chk(string tag, longint got, longint exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // reference model: run phases 0 idle,1 setup,2 settle,3 trigger,4 waiting,5 store,6 finish
    int ms = 0, mcnt = 0, mptr = 0, mlen = 1, mstores = 0;
    bit mdone = 0, mmode = 0;
    longint mfcw = 0, msample = 0, msettle = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ms = 0; mdone = 0;
        end else begin
            case (ms)
                0: if (start) begin
                    ms = 1; mdone = 0; mmode = mode; mfcw = fcw; msettle = settle;
                    mlen = 1 << ((klog > ADDR_W) ? ADDR_W : klog); mptr = 0; mstores = 0;
                end
                1: begin ms = 2; mcnt = int'(msettle); end
                2: if (mcnt == 0) ms = 3; else mcnt--;
                3: ms = 4;
                4: if (adc_done) begin msample = adc_data; ms = 5; end
                5: begin mstores++; if (mptr == mlen - 1) ms = 6; else begin mptr++; ms = 3; end end
                6: begin mdone = 1; ms = 0; end
                default: ms = 0;
            endcase
        end
        if (cyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    // ADC responder and per-cycle comparison, both away from the active edge
    int lat = 1, pend = 0;
    bit spur = 0;
    logic [DATA_W-1:0] nextval = 12'h135;

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 R4 soc", soc_o, ms == 3);
            chk("R6 write enable", we_o, ms == 5);
            if (ms == 5) begin
                chk("R6 R7 address", addr_o, mptr);
                chk("R5 R6 data", wdata_o, msample);
            end
            chk("R8 done flag", done_o, mdone);
            chk("R2 R10 adc select", ain_o, ms != 0);
            chk("R2 R10 dac source", src_o, (ms != 0) && mmode);
            chk("R2 R10 clock enable", clken_o, (ms != 0) && mmode);
            chk("R2 R10 frequency word", fcw_o, (ms != 0) ? mfcw : 0);
        end
        adc_done = 0;
        if (spur) begin
            adc_done = 1; adc_data = 12'hFFF; spur = 0;
        end else if (soc_o) begin
            pend = lat;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                adc_done = 1; adc_data = nextval; nextval = nextval + 12'd37;
            end
        end
    end

    task automatic run(bit md, int f, int k, int s, int l, bit inject, bit restart, int exp_stores);
        int t;
        @(negedge clk);
        mode = md; fcw = FCW_W'(f); klog = LEN_W'(k); settle = SETTLE_W'(s); lat = l;
        start = 1;
        @(negedge clk);
        start = 0;
        if (inject) spur = 1;          // stray done during setup/settle (R5)
        repeat (s + 6) @(negedge clk);
        if (restart) begin
            start = 1; mode = ~md; klog = 0;   // ignored while busy (R9)
            @(negedge clk);
            start = 0;
        end
        t = 0;
        while (!done_o && t < 20000) begin @(negedge clk); t++; end
        chk("R7 R9 stores per run", mstores, exp_stores);
        chk("R8 done after run", done_o, 1);
        repeat (3) @(negedge clk);
        chk("R8 done persists", done_o, 1);
        chk("R10 idle select", ain_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset soc", soc_o, 0);
        chk("R1 reset we", we_o, 0);
        chk("R1 reset done", done_o, 0);
        chk("R1 reset selects", {ain_o, src_o, clken_o}, 0);
        chk("R1 reset fcw", fcw_o, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        run(1, 24'h01E240, 2, 3, 1, 0, 0, 4);
        run(0, 24'h00ABCD, 3, 0, 4, 1, 1, 8);
        run(1, 24'h7FFFFF, 0, 5, 2, 1, 0, 1);
        run(1, 24'h000321, 9, 2, 1, 0, 0, 256);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule